// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a small multi-cycle processor. It holds a ten-state machine whose outputs depend only on the current state. Every instruction begins with the same two states. The first state fetches the instruction and advances the program counter. The second state decodes it and reads the registers.

After decode the machine takes one of four paths, chosen by the 6-bit opcode: the register-to-register ALU path, the load/store address path, the conditional branch path, or the jump path. The path it takes sets the instruction's length to 3, 4 or 5 cycles. The machine then returns to fetch.

The outputs steer a shared datapath that is outside this block: memory address source, memory strobes, instruction register load, ALU operand and operation selects, program-counter updates, and register-file write controls. The current state is also an output, so that the sequence can be observed.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst` is high, the state register is loaded with fetch on every rising clock edge. The state codes are: fetch 0, decode 1, address 2, load-read 3, load-writeback 4, store-write 5, ALU-execute 6, ALU-writeback 7, branch 8, jump 9.
- R2: In fetch, the outputs are `mem_rd`=1, `ir_load`=1, `pc_load`=1, `alu_b_sel`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_op`=0 and `pc_src`=0. The next state is always decode.
- R3: In decode, `alu_b_sel`=3, `alu_a_sel`=0 and `alu_op`=0. The next state depends on the opcode:
  - 000000 goes to ALU-execute.
  - 100011 (load) and 101011 (store) go to address.
  - 000100 goes to branch.
  - 000010 goes to jump.
- R4: ALU-execute drives `alu_a_sel`=1, `alu_b_sel`=0 and `alu_op`=2, then moves to ALU-writeback. ALU-writeback drives `rf_wr`=1, `rf_dst_sel`=1 and `rf_from_mem`=0, then moves to fetch.
- R5: Branch drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1, `pc_load_cond`=1 and `pc_src`=1, then moves to fetch.
- R6: Jump drives `pc_load`=1 and `pc_src`=2, then moves to fetch.
- R7: Address drives `alu_a_sel`=1, `alu_b_sel`=2 and `alu_op`=0. For a load it then goes to load-read, which drives `mem_rd`=1 and `addr_sel`=1. Load-read is followed by load-writeback, which drives `rf_wr`=1, `rf_dst_sel`=0 and `rf_from_mem`=1.
- R8: For a store, address is followed by store-write, which drives `mem_wr`=1 and `addr_sel`=1, then fetch.
- R9: Any other opcode in decode sends the machine back to fetch. No write or strobe output is asserted on that path.
- R10: Instruction lengths from one fetch to the next are:
  - ALU: 4 cycles
  - branch: 3 cycles
  - jump: 3 cycles
  - load: 5 cycles
  - store: 4 cycles
- R11: Every output that a state does not name is 0. `mem_rd` and `mem_wr` are never high together. Unused state codes 10 to 15 drive all outputs to 0 and go to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction opcode, sampled in decode |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load enable |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 0 register B, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_op | output | 2 | ALU operation class: 0 add, 1 subtract, 2 function field |
| pc_load | output | 1 | Unconditional program counter write |
| pc_load_cond | output | 1 | Program counter write qualified by ALU zero |
| pc_src | output | 2 | Program counter source: 0 ALU, 1 ALU result register, 2 jump target |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| rf_from_mem | output | 1 | Register write data: 0 ALU result, 1 memory data |
| state | output | 4 | Current state code |

## Verification
The bench runs each instruction class end to end and compares the state and all sixteen control bits on every cycle against the table in the requirements. It also checks that the machine returns to fetch after exactly the required number of cycles. A dispatch that mixes up load and store would show either a missing writeback cycle or a write strobe where a read belongs. Two opcodes one bit away from valid codes must fall back to fetch without touching any enable; a decoder that ignores some opcode bits would send them into a real path instead. A reset raised in the middle of a load must land the machine in fetch with no writeback; a reset that only held the state would leave the register write pending.

// File: rtl/mc_sequencer.sv
module mc_sequencer (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_load,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic       pc_load,
  output logic       pc_load_cond,
  output logic [1:0] pc_src,
  output logic       rf_wr,
  output logic       rf_dst_sel,
  output logic       rf_from_mem,
  output logic [3:0] state
);

  localparam logic [3:0] ST_FETCH = 4'd0;
  localparam logic [3:0] ST_DEC   = 4'd1;
  localparam logic [3:0] ST_ADDR  = 4'd2;
  localparam logic [3:0] ST_LDRD  = 4'd3;
  localparam logic [3:0] ST_LDWB  = 4'd4;
  localparam logic [3:0] ST_STWR  = 4'd5;
  localparam logic [3:0] ST_AEXE  = 4'd6;
  localparam logic [3:0] ST_AWB   = 4'd7;
  localparam logic [3:0] ST_BR    = 4'd8;
  localparam logic [3:0] ST_JMP   = 4'd9;

  localparam logic [5:0] OP_ALU   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JMP   = 6'b000010;

  logic [3:0] cur, nxt;

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_FETCH;
    else     cur <= nxt;
  end

  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH: nxt = ST_DEC;
      ST_DEC: begin
        case (opcode)
          OP_ALU:            nxt = ST_AEXE;
          OP_LOAD, OP_STORE: nxt = ST_ADDR;
          OP_BEQ:            nxt = ST_BR;
          OP_JMP:            nxt = ST_JMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:  nxt = (opcode == OP_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:  nxt = ST_LDWB;
      ST_AEXE:  nxt = ST_AWB;
      default:  nxt = ST_FETCH;
    endcase
  end

  assign state        = cur;
  assign addr_sel     = (cur == ST_LDRD) || (cur == ST_STWR);
  assign mem_rd       = (cur == ST_FETCH) || (cur == ST_LDRD);
  assign mem_wr       = (cur == ST_STWR);
  assign ir_load      = (cur == ST_FETCH);
  assign alu_a_sel    = (cur == ST_ADDR) || (cur == ST_AEXE) || (cur == ST_BR);
  assign alu_b_sel    = (cur == ST_FETCH) ? 2'd1 :
                        (cur == ST_DEC)   ? 2'd3 :
                        (cur == ST_ADDR)  ? 2'd2 : 2'd0;
  assign alu_op       = (cur == ST_AEXE) ? 2'd2 :
                        (cur == ST_BR)   ? 2'd1 : 2'd0;
  assign pc_load      = (cur == ST_FETCH) || (cur == ST_JMP);
  assign pc_load_cond = (cur == ST_BR);
  assign pc_src       = (cur == ST_BR)  ? 2'd1 :
                        (cur == ST_JMP) ? 2'd2 : 2'd0;
  assign rf_wr        = (cur == ST_AWB) || (cur == ST_LDWB);
  assign rf_dst_sel   = (cur == ST_AWB);
  assign rf_from_mem  = (cur == ST_LDWB);

  assert_reset_to_fetch_R1: assert property (@(posedge clk)
    rst |=> cur == ST_FETCH);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    cur == ST_FETCH |=> cur == ST_DEC);

  assert_alu_exec_then_wb_R4: assert property (@(posedge clk) disable iff (rst)
    cur == ST_AEXE |=> (cur == ST_AWB) && rf_wr && rf_dst_sel);

  assert_load_read_then_wb_R7: assert property (@(posedge clk) disable iff (rst)
    cur == ST_LDRD |=> (cur == ST_LDWB) && rf_from_mem && !rf_dst_sel);

  assert_store_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> addr_sel && !mem_rd && !rf_wr && !pc_load);

  assert_unknown_opcode_R9: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_DEC) && (opcode != OP_ALU) && (opcode != OP_LOAD) &&
    (opcode != OP_STORE) && (opcode != OP_BEQ) && (opcode != OP_JMP)
    |=> cur == ST_FETCH);

  assert_terminal_returns_R10: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_AWB || cur == ST_BR || cur == ST_JMP || cur == ST_LDWB || cur == ST_STWR)
    |=> cur == ST_FETCH);

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_single_pc_path_R11: assert property (@(posedge clk) disable iff (rst)
    !(pc_load && pc_load_cond));

endmodule

// File: tb/mc_sequencer_bench.sv
module mc_sequencer_bench;
  logic clk = 0;
  logic rst = 1;
  logic [5:0] opcode = 6'd0;
  logic addr_sel, mem_rd, mem_wr, ir_load, alu_a_sel, pc_load, pc_load_cond;
  logic rf_wr, rf_dst_sel, rf_from_mem;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic [3:0] state;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mc_sequencer u_mc_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .pc_load(pc_load), .pc_load_cond(pc_load_cond), .pc_src(pc_src),
    .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel), .rf_from_mem(rf_from_mem),
    .state(state)
  );

  // packing: addr_sel mem_rd mem_wr ir_load alu_a b[1:0] op[1:0] pcl pcc src[1:0] rfw dst mem
  function automatic logic [15:0] expect_ctl(input logic [3:0] s);
    case (s)
      4'd0: return 16'b0_1_0_1_0_01_00_1_0_00_0_0_0;
      4'd1: return 16'b0_0_0_0_0_11_00_0_0_00_0_0_0;
      4'd2: return 16'b0_0_0_0_1_10_00_0_0_00_0_0_0;
      4'd3: return 16'b1_1_0_0_0_00_00_0_0_00_0_0_0;
      4'd4: return 16'b0_0_0_0_0_00_00_0_0_00_1_0_1;
      4'd5: return 16'b1_0_1_0_0_00_00_0_0_00_0_0_0;
      4'd6: return 16'b0_0_0_0_1_00_10_0_0_00_0_0_0;
      4'd7: return 16'b0_0_0_0_0_00_00_0_0_00_1_1_0;
      4'd8: return 16'b0_0_0_0_1_00_01_0_1_01_0_0_0;
      4'd9: return 16'b0_0_0_0_0_00_00_1_0_10_0_0_0;
      default: return 16'b0;
    endcase
  endfunction

  function automatic logic [15:0] actual_ctl();
    return {addr_sel, mem_rd, mem_wr, ir_load, alu_a_sel, alu_b_sel, alu_op,
            pc_load, pc_load_cond, pc_src, rf_wr, rf_dst_sel, rf_from_mem};
  endfunction

  task automatic check_state(input string req, input logic [3:0] exp_s);
    checks++;
    if (state !== exp_s) begin
      errors++;
      $display("FAIL %s state actual %0d expected %0d", req, state, exp_s);
    end
    checks++;
    if (actual_ctl() !== expect_ctl(exp_s)) begin
      errors++;
      $display("FAIL %s controls in state %0d actual %b expected %b",
               req, exp_s, actual_ctl(), expect_ctl(exp_s));
    end
  endtask

  // seq holds up to five 4-bit state codes, first at bits [3:0]
  task automatic run_instr(input string req, input logic [5:0] op,
                           input logic [19:0] seq, input int len);
    opcode = op;
    for (int i = 0; i < len; i++) begin
      check_state(req, seq[i*4 +: 4]);
      @(negedge clk);
    end
    check_state({req, " R10 length"}, 4'd0);
  endtask

  task automatic test_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    check_state("R1 in reset", 4'd0);
    rst = 0;
    check_state("R1 after reset", 4'd0);
  endtask

  task automatic test_alu();   run_instr("R2 R3 R4 alu", 6'b000000, {4'd0, 4'd0, 4'd7, 4'd6, 4'd1, 4'd0} , 4); endtask
  task automatic test_load();  run_instr("R7 load", 6'b100011, {4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 5); endtask
  task automatic test_store(); run_instr("R8 store", 6'b101011, {4'd0, 4'd5, 4'd2, 4'd1, 4'd0}, 4); endtask
  task automatic test_branch(); run_instr("R5 branch", 6'b000100, {4'd0, 4'd0, 4'd8, 4'd1, 4'd0}, 3); endtask
  task automatic test_jump();  run_instr("R6 jump", 6'b000010, {4'd0, 4'd0, 4'd9, 4'd1, 4'd0}, 3); endtask

  task automatic test_unknown();
    run_instr("R9 R11 unknown 000110", 6'b000110, {4'd0, 4'd0, 4'd0, 4'd1, 4'd0}, 2);
    run_instr("R9 R11 unknown 100010", 6'b100010, {4'd0, 4'd0, 4'd0, 4'd1, 4'd0}, 2);
  endtask

  task automatic test_mid_reset();
    opcode = 6'b100011;
    check_state("R1 mid fetch", 4'd0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check_state("R7 mid load-read", 4'd3);
    rst = 1;
    @(negedge clk);
    check_state("R1 reset during load", 4'd0);
    rst = 0;
    @(negedge clk);
    check_state("R1 restart decode", 4'd1);
    opcode = 6'b000010;
    @(negedge clk);
    check_state("R6 after restart", 4'd9);
    @(negedge clk);
    check_state("R10 back to fetch", 4'd0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_alu();
    test_load();
    test_store();
    test_branch();
    test_jump();
    test_unknown();
    test_load();
    test_alu();
    test_mid_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule